// File: doc/BRIEF.md
# Banked RAM Window and Port Decoder

This block sits between a 16-bit processor bus and an expansion card. The card carries an external 32 KB SRAM, a boot ROM and one byte-wide I/O port. The block decodes each bus address into one of four regions: banked RAM window, port, ROM, or nothing. It drives active-low chip selects for the SRAM and the ROM. It also forms the 15-bit physical SRAM address from a 3-bit page number and the low 12 address bits.

The port is a single address at the top of the RAM window, so each page holds 4095 usable bytes. A write to the port stores the whole data byte in an output register. Three bits of that register pick the RAM page. Three other bits drive a software-driven SPI link to an SD card: chip select, clock and MOSI. A read of the port returns a byte built from a general input bus, with two substitutions: the SD card MISO line replaces bit 0, and the current page replaces bits 1 to 3.

The decode, the SRAM address and the read data are combinational. The port register is clocked, and it captures the bus data on the clock edge that first sees the write strobe high.

Top module: `mwin_bank_port`

## Requirements
- R1: Address EFFFh with a read or write strobe selects the port. Both sram_cs_n and rom_cs_n then stay high.
- R2: Addresses E000h to EFFEh with a strobe drive sram_cs_n low. sram_addr equals {page, addr[11:0]} at all times.
- R3: Addresses F000h to F7FFh with a strobe drive rom_cs_n low. F800h and every address below E000h leave it high.
- R4: With neither bus_rd nor bus_wr high, sram_cs_n, rom_cs_n and rdata_oe are all inactive, whatever the address.
- R5: The first clock edge that sees bus_wr high at EFFFh loads bus_wdata into port_out, and the new value shows after that edge. While bus_wr stays high, later edges do not load again, even if bus_wdata changes.
- R6: Reset sets port_out to 00h, which selects page 0 and drives sd_cs_n, sd_sck and sd_mosi low.
- R7: The page is port_out bits 3:1 (bit 1 least significant). It appears on sram_addr[14:12].
- R8: A read of EFFFh drives rdata_oe high. rdata bit 0 is sd_miso, bits 3:1 are the page, and bits 7:4 are gp_in[7:4].
- R9: For any other address, or when bus_rd is low, rdata_oe is low and rdata is 00h.
- R10: sd_cs_n follows port_out bit 4, sd_sck follows bit 5 and sd_mosi follows bit 6.
- R11: A write to any address other than EFFFh leaves port_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Processor write data |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| gp_in | input | 8 | General input bus read back through the port |
| sd_miso | input | 1 | Serial data from the SD card |
| rdata | output | 8 | Read data toward the processor |
| rdata_oe | output | 1 | High while this block drives read data |
| sram_cs_n | output | 1 | External SRAM chip select, active low |
| sram_addr | output | 15 | Physical SRAM address |
| rom_cs_n | output | 1 | Boot ROM chip select, active low |
| port_out | output | 8 | Port output register |
| sd_cs_n | output | 1 | SD card chip select |
| sd_sck | output | 1 | SD card serial clock |
| sd_mosi | output | 1 | Serial data to the SD card |

## Verification
The chip selects, sram_addr, rdata and rdata_oe are combinational. The bench applies each bus pattern on a falling clock edge and checks these outputs one nanosecond later, before the next rising edge. port_out and the SD lines change one rising edge after the write strobe first appears at EFFFh. Each write therefore raises the strobe at a falling edge and drops it at the next falling edge. The result is checked just after that second falling edge, and again after more edges to confirm that nothing loads twice.

// File: rtl/mwin_pkg.sv
package mwin_pkg;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_RAM  = 2'd1,
      RGN_PORT = 2'd2,
      RGN_ROM  = 2'd3
   } region_t;

endpackage

// File: rtl/mwin_decode.sv
module mwin_decode
   import mwin_pkg::*;
#(
   parameter int              ADDR_W        = 16,
   parameter int              TAG_W         = 4,
   parameter logic [3:0]      WIN_TAG       = 4'hE,
   parameter bit              PORT_AT_TOP   = 1'b1,
   parameter logic [15:0]     ROM_BASE      = 16'hF000,
   parameter int              ROM_SPAN_LOG2 = 11
) (
   input  logic [ADDR_W-1:0] addr,
   output region_t           region
);
   localparam int LOW_W = ADDR_W - TAG_W;

   initial begin
      assert (TAG_W > 0 && TAG_W <= 4 && TAG_W < ADDR_W)
         else $error("mwin_decode: TAG_W out of range");
      assert (ROM_SPAN_LOG2 > 0 && ROM_SPAN_LOG2 < ADDR_W && ADDR_W <= 16)
         else $error("mwin_decode: ROM span out of range");
   end

   logic [TAG_W-1:0]  tag;
   logic [LOW_W-1:0]  low;
   logic              win_hit;
   logic              port_hole;
   logic              rom_hit;

   assign tag     = addr[ADDR_W-1 -: TAG_W];
   assign low     = addr[LOW_W-1:0];
   assign win_hit = (tag == WIN_TAG[TAG_W-1:0]);
   assign rom_hit = (addr[ADDR_W-1:ROM_SPAN_LOG2] == ROM_BASE[ADDR_W-1:ROM_SPAN_LOG2]);

   generate
      if (PORT_AT_TOP) begin : g_port_top
         assign port_hole = &low;
      end else begin : g_port_bottom
         assign port_hole = ~|low;
      end
   endgenerate

   always_comb begin
      region = RGN_NONE;
      if (win_hit) begin
         region = port_hole ? RGN_PORT : RGN_RAM;
      end else if (rom_hit) begin
         region = RGN_ROM;
      end
   end

endmodule

// File: rtl/mwin_port_reg.sv
module mwin_port_reg #(
   parameter int              DATA_W    = 8,
   parameter logic [7:0]      RESET_VAL = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   initial begin
      assert (DATA_W > 0 && DATA_W <= 8)
         else $error("mwin_port_reg: DATA_W out of range");
   end

   logic wr_q;
   logic wr_rise;
   logic load;

   assign wr_rise = wr & ~wr_q;
   assign load    = wr_rise & sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= 1'b0;
         q    <= RESET_VAL[DATA_W-1:0];
      end else begin
         wr_q <= wr;
         if (load) begin
            q <= wdata;
         end
      end
   end

   AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !wr_q && sel) |=> (q == $past(wdata)));  // R5

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && !wr_q && sel) |=> $stable(q));  // R11

endmodule

// File: rtl/mwin_rd_mux.sv
module mwin_rd_mux #(
   parameter int DATA_W   = 8,
   parameter int PAGE_W   = 3,
   parameter int PAGE_LSB = 1,
   parameter int MISO_BIT = 0
) (
   input  logic              en,
   input  logic [PAGE_W-1:0] page,
   input  logic              miso,
   input  logic [DATA_W-1:0] gp_in,
   output logic [DATA_W-1:0] rdata
);
   initial begin
      assert (PAGE_LSB + PAGE_W <= DATA_W)
         else $error("mwin_rd_mux: page field exceeds data width");
      assert (MISO_BIT < PAGE_LSB || MISO_BIT >= PAGE_LSB + PAGE_W)
         else $error("mwin_rd_mux: MISO bit overlaps page field");
   end

   logic [DATA_W-1:0] rd_byte;
   logic              unused_gp;

   assign unused_gp = gp_in[MISO_BIT] ^ (^gp_in[PAGE_LSB +: PAGE_W]);

   generate
      for (genvar k = 0; k < DATA_W; k++) begin : g_bit
         if (k == MISO_BIT) begin : g_miso
            assign rd_byte[k] = miso;
         end else if (k >= PAGE_LSB && k < PAGE_LSB + PAGE_W) begin : g_page
            assign rd_byte[k] = page[k-PAGE_LSB];
         end else begin : g_gp
            assign rd_byte[k] = gp_in[k];
         end
      end
   endgenerate

   assign rdata = en ? rd_byte : '0;

endmodule

// File: rtl/mwin_bank_port.sv
module mwin_bank_port
   import mwin_pkg::*;
#(
   parameter int          ADDR_W        = 16,
   parameter int          DATA_W        = 8,
   parameter int          TAG_W         = 4,
   parameter logic [3:0]  WIN_TAG       = 4'hE,
   parameter bit          PORT_AT_TOP   = 1'b1,
   parameter logic [15:0] ROM_BASE      = 16'hF000,
   parameter int          ROM_SPAN_LOG2 = 11,
   parameter int          PAGE_W        = 3,
   parameter int          PAGE_LSB      = 1,
   parameter int          MISO_BIT      = 0,
   parameter int          SD_CS_BIT     = 4,
   parameter int          SD_SCK_BIT    = 5,
   parameter int          SD_MOSI_BIT   = 6,
   parameter logic [7:0]  PORT_RESET    = 8'h00
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [ADDR_W-1:0]                  bus_addr,
   input  logic [DATA_W-1:0]                  bus_wdata,
   input  logic                               bus_rd,
   input  logic                               bus_wr,
   input  logic [DATA_W-1:0]                  gp_in,
   input  logic                               sd_miso,
   output logic [DATA_W-1:0]                  rdata,
   output logic                               rdata_oe,
   output logic                               sram_cs_n,
   output logic [PAGE_W+ADDR_W-TAG_W-1:0]     sram_addr,
   output logic                               rom_cs_n,
   output logic [DATA_W-1:0]                  port_out,
   output logic                               sd_cs_n,
   output logic                               sd_sck,
   output logic                               sd_mosi
);
   localparam int LOW_W = ADDR_W - TAG_W;

   initial begin
      assert (SD_CS_BIT < DATA_W && SD_SCK_BIT < DATA_W && SD_MOSI_BIT < DATA_W)
         else $error("mwin_bank_port: SD bit outside port");
      assert (PAGE_LSB + PAGE_W <= DATA_W)
         else $error("mwin_bank_port: page field outside port");
   end

   region_t           region;
   logic              strobe;
   logic              port_sel;
   logic [PAGE_W-1:0] page;

   mwin_decode #(
      .ADDR_W        (ADDR_W),
      .TAG_W         (TAG_W),
      .WIN_TAG       (WIN_TAG),
      .PORT_AT_TOP   (PORT_AT_TOP),
      .ROM_BASE      (ROM_BASE),
      .ROM_SPAN_LOG2 (ROM_SPAN_LOG2)
   ) u_decode (
      .addr   (bus_addr),
      .region (region)
   );

   assign strobe   = bus_rd | bus_wr;
   assign port_sel = (region == RGN_PORT);

   mwin_port_reg #(
      .DATA_W    (DATA_W),
      .RESET_VAL (PORT_RESET)
   ) u_port (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (port_sel),
      .wr    (bus_wr),
      .wdata (bus_wdata),
      .q     (port_out)
   );

   assign page      = port_out[PAGE_LSB +: PAGE_W];
   assign sram_addr = {page, bus_addr[LOW_W-1:0]};
   assign sram_cs_n = ~((region == RGN_RAM) & strobe);
   assign rom_cs_n  = ~((region == RGN_ROM) & strobe);
   assign rdata_oe  = port_sel & bus_rd;

   assign sd_cs_n = port_out[SD_CS_BIT];
   assign sd_sck  = port_out[SD_SCK_BIT];
   assign sd_mosi = port_out[SD_MOSI_BIT];

   mwin_rd_mux #(
      .DATA_W   (DATA_W),
      .PAGE_W   (PAGE_W),
      .PAGE_LSB (PAGE_LSB),
      .MISO_BIT (MISO_BIT)
   ) u_rd_mux (
      .en    (rdata_oe),
      .page  (page),
      .miso  (sd_miso),
      .gp_in (gp_in),
      .rdata (rdata)
   );

   AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!sram_cs_n && !rom_cs_n));  // R1

   AST_PORT_NOT_RAM: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> (sram_cs_n && rom_cs_n));  // R1

   AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd && !bus_wr) |-> (sram_cs_n && rom_cs_n && !rdata_oe));  // R4

   AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_oe |-> (rdata == '0));  // R9

   AST_PAGE_ON_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_cs_n |-> (sram_addr[PAGE_W+LOW_W-1:LOW_W] == port_out[PAGE_LSB +: PAGE_W]));  // R7

endmodule

// File: tb/tb_mwin_bank_port.sv
`timescale 1ns/1ps
module tb_mwin_bank_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic [7:0]  bus_wdata = 8'h00;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  gp_in = 8'h00;
   logic        sd_miso = 1'b0;
   logic [7:0]  rdata;
   logic        rdata_oe;
   logic        sram_cs_n;
   logic [14:0] sram_addr;
   logic        rom_cs_n;
   logic [7:0]  port_out;
   logic        sd_cs_n;
   logic        sd_sck;
   logic        sd_mosi;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   mwin_bank_port dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .gp_in     (gp_in),
      .sd_miso   (sd_miso),
      .rdata     (rdata),
      .rdata_oe  (rdata_oe),
      .sram_cs_n (sram_cs_n),
      .sram_addr (sram_addr),
      .rom_cs_n  (rom_cs_n),
      .port_out  (port_out),
      .sd_cs_n   (sd_cs_n),
      .sd_sck    (sd_sck),
      .sd_mosi   (sd_mosi)
   );

   // vector fields: addr[20:5] rd[4] wr[3] exp_sram_cs_n[2] exp_rom_cs_n[1] exp_oe[0]
   localparam int NV = 12;
   localparam logic [20:0] VEC [NV] = '{
      {16'hE000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      {16'hEFFE, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      {16'hEFFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
      {16'hF000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      {16'hF7FF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      {16'hF800, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
      {16'hDFFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
      {16'hE800, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
      {16'hF123, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
      {16'hEFFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
      {16'hE555, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
      {16'hF400, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      #1;
   endtask

   initial begin
      #20000;
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      bus_addr = 16'hE123;
      #1;
      // R6 reset state
      chk("R6", "port_out in reset", port_out, 8'h00);
      chk("R6", "sd lines in reset", {sd_cs_n, sd_sck, sd_mosi}, 3'b000);
      chk("R7", "page 0 address", sram_addr, 15'h0123);
      rst_n = 1'b1;

      // decode table walk (R2 R3 R4 R9 columns)
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         bus_addr = VEC[i][20:5];
         bus_rd   = VEC[i][4];
         bus_wr   = VEC[i][3];
         #1;
         chk("R2", "sram_cs_n", sram_cs_n, VEC[i][2]);
         chk("R3", "rom_cs_n", rom_cs_n, VEC[i][1]);
         chk("R9", "rdata_oe", rdata_oe, VEC[i][0]);
      end
      @(negedge clk);
      bus_rd = 1'b0;
      bus_wr = 1'b0;
      #1;
      chk("R11", "port_out after table writes", port_out, 8'h00);
      chk("R4", "idle selects", {sram_cs_n, rom_cs_n, rdata_oe}, 3'b110);

      // R5 full byte load
      bus_write(16'hEFFF, 8'hFF);
      chk("R5", "port_out FF", port_out, 8'hFF);
      bus_addr = 16'hE000;
      #1;
      chk("R7", "page 7 address", sram_addr, 15'h7000);

      // R10 R7 second pattern
      bus_write(16'hEFFF, 8'h5A);
      chk("R5", "port_out 5A", port_out, 8'h5A);
      chk("R10", "sd cs/sck/mosi", {sd_cs_n, sd_sck, sd_mosi}, 3'b101);
      bus_addr = 16'hE7AB;
      bus_rd   = 1'b1;
      #1;
      chk("R2", "sram_cs_n low in window", sram_cs_n, 1'b0);
      chk("R7", "page 5 address", sram_addr, 15'h57AB);

      // R8 port reads with both MISO levels
      bus_addr = 16'hEFFF;
      gp_in    = 8'hA5;
      sd_miso  = 1'b0;
      #1;
      chk("R8", "read miso 0", rdata, 8'hAA);
      chk("R8", "rdata_oe", rdata_oe, 1'b1);
      chk("R1", "no chip select at port", {sram_cs_n, rom_cs_n}, 2'b11);
      sd_miso = 1'b1;
      #1;
      chk("R8", "read miso 1", rdata, 8'hAB);
      bus_addr = 16'hEFFE;
      #1;
      chk("R9", "rdata quiet off port", rdata, 8'h00);
      @(negedge clk);
      bus_rd = 1'b0;

      // R11 write elsewhere ignored
      bus_write(16'hE000, 8'h77);
      chk("R11", "RAM write leaves port", port_out, 8'h5A);
      bus_write(16'hF000, 8'h33);
      chk("R11", "ROM write leaves port", port_out, 8'h5A);

      // R5 held strobe loads once
      @(negedge clk);
      bus_addr  = 16'hEFFF;
      bus_wdata = 8'h11;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wdata = 8'h22;
      repeat (3) @(negedge clk);
      #1;
      chk("R5", "held strobe no reload", port_out, 8'h11);
      bus_wr = 1'b0;
      #1;
      chk("R5", "after release", port_out, 8'h11);

      // R6 reset again
      bus_write(16'hEFFF, 8'h7E);
      rst_n = 1'b0;
      #1;
      chk("R6", "port_out cleared by reset", port_out, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule